// File: doc/BRIEF.md
# Configurable External Interrupt Sense Unit

This block monitors up to eight asynchronous external interrupt request lines and turns them into latched, clock-domain-safe status flags. Each line is brought in through a synchronizer. Each line then has its own two-bit sense selection that decides which condition raises its flag: the line being low, a falling transition, a rising transition, or either transition.

Software reaches the block through a small byte-wide register port. The port has a single-cycle write strobe and a combinational read path. Two bytes hold the sense selections, and a third byte exposes the status flags. A flag can only be dropped by writing a zero to its bit. Writing a one leaves the bit alone, so software can acknowledge a subset of lines without disturbing the rest, and it has no means to raise a flag itself.

The flags drive one request output per line and a single combined request. Priority handling, masking and vectoring are left to the interrupt controller downstream.

Top module: `xirq_sense`

## Requirements
- R1: After reset the sense-control bytes and the status byte read 0x00, and `line_req` and `any_req` are low, so every line starts in low-level mode.
- R2: Line n's sense selection sits in bits 2n+1:2n of a 16-bit control word. Address 0 reads and writes bits 7:0 (lines 3..0), and address 1 reads and writes bits 15:8 (lines 7..4). Written values read back unchanged.
- R3: Selection 00 (low level) sets the flag on every cycle the synchronized line is low. A zero written to that flag while the line is still low leaves it set.
- R4: Selection 01 sets the flag on a high-to-low transition of the line only.
- R5: Selection 10 sets the flag on a low-to-high transition of the line only.
- R6: Selection 11 sets the flag on transitions in either direction.
- R7: A change at `irq_in` passes two synchronizer stages. It is not visible in the flags after the second rising clock edge, and it is visible after the third.
- R8: At address 2, a write with bit n = 0 clears flag n, and bit n = 1 leaves it unchanged. A write never sets a flag.
- R9: When a sense event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `line_req[n]` equals flag n, and `any_req` is the OR of all flags.
- R11: Address 2 reads the flags, with bit n being line n. Address 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Asynchronous external request lines |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| line_req | output | NLINES | Per-line request, one per flag |
| any_req | output | 1 | OR of all flags |

## Verification
Two functions can act on the same flag in one cycle: the sense logic setting it, and a status write clearing it. The bench lines them up by changing a line that is in rising-edge mode, waiting two clock edges, and then strobing a clear of that already-set flag, so that both land on the third edge. The flag must then still read as set. A separate clear issued after the line has settled must drop the flag, which shows the clear path does work. In low-level mode the same collision is provoked by clearing while the line is held low, and the flag must remain set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   localparam logic [1:0] ADR_CTL_LO = 2'd0;
   localparam logic [1:0] ADR_CTL_HI = 2'd1;
   localparam logic [1:0] ADR_STAT   = 2'd2;

   function automatic logic sense_hit(sense_e mode, logic cur, logic old);
      case (mode)
         SENSE_LOW:  return !cur;
         SENSE_FALL: return old & !cur;
         SENSE_RISE: return !old & cur;
         default:    return old ^ cur;
      endcase
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int   WIDTH   = 8,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out,
   output logic [WIDTH-1:0] prev_out
);
   genvar s;
   for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= {WIDTH{RST_VAL}};
            else        q <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= {WIDTH{RST_VAL}};
            else        q <= g_stage[s-1].q;
      end
   end

   assign sync_out = g_stage[STAGES-1].q;

   logic [WIDTH-1:0] prev_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= {WIDTH{RST_VAL}};
      else        prev_q <= sync_out;

   assign prev_out = prev_q;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
   import xirq_pkg::*;
#(
   parameter int NLINES = 8,
   localparam int MODE_W = 2 * NLINES
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [NLINES-1:0] cur,
   input  logic [NLINES-1:0] old,
   output logic [NLINES-1:0] hit
);
   genvar i;
   for (i = 0; i < NLINES; i++) begin : g_line
      assign hit[i] = sense_hit(sense_e'(mode[2*i +: 2]), cur[i], old[i]);
   end
endmodule

// File: rtl/xirq_flags.sv
module xirq_flags #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] set,
   input  logic              clr_en,
   input  logic [NLINES-1:0] clr_data,
   output logic [NLINES-1:0] flags
);
   logic [NLINES-1:0] flag_q;
   logic [NLINES-1:0] clr_mask;

   assign clr_mask = clr_en ? ~clr_data : '0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_mask) | set;

   assign flags = flag_q;
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
   import xirq_pkg::*;
#(
   parameter int NLINES      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [NLINES-1:0] line_req,
   output logic              any_req
);
   localparam int          MODE_W   = 2 * NLINES;
   localparam logic [15:0] CTL_MASK = 16'((32'd1 << MODE_W) - 32'd1);

   if (NLINES < 1 || NLINES > 8) begin : g_bad_lines
      $error("xirq_sense: NLINES must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xirq_sense: SYNC_STAGES must be at least 2");
   end

   logic [15:0]       ctl_q;
   logic [NLINES-1:0] cur, old, hit, flags;
   logic              wr_lo, wr_hi, wr_stat;

   assign wr_lo   = wr_en && (addr == ADR_CTL_LO);
   assign wr_hi   = wr_en && (addr == ADR_CTL_HI);
   assign wr_stat = wr_en && (addr == ADR_STAT);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_lo) ctl_q[7:0]  <= wdata & CTL_MASK[7:0];
         if (wr_hi) ctl_q[15:8] <= wdata & CTL_MASK[15:8];
      end

   xirq_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(irq_in),
      .sync_out(cur), .prev_out(old)
   );

   xirq_detect #(.NLINES(NLINES)) u_detect (
      .mode(ctl_q[MODE_W-1:0]), .cur(cur), .old(old), .hit(hit)
   );

   xirq_flags #(.NLINES(NLINES)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(hit),
      .clr_en(wr_stat), .clr_data(wdata[NLINES-1:0]), .flags(flags)
   );

   logic [7:0] stat_byte;
   always_comb begin
      stat_byte = '0;
      stat_byte[NLINES-1:0] = flags;
   end

   always_comb begin
      case (addr)
         ADR_CTL_LO: rdata = ctl_q[7:0];
         ADR_CTL_HI: rdata = ctl_q[15:8];
         ADR_STAT:   rdata = stat_byte;
         default:    rdata = 8'h00;
      endcase
   end

   assign line_req = flags;
   assign any_req  = |flags;
endmodule

// File: rtl/xirq_sense_chk.sv
module xirq_sense_chk #(
   parameter int NLINES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NLINES-1:0] irq_in,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [7:0]        wdata,
   input logic [15:0]       ctl_q,
   input logic [NLINES-1:0] line_req,
   input logic              any_req
);
   logic [1:0] age;
   logic       stat_wr;
   assign stat_wr = wr_en && (addr == 2'd2);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;

   always @(negedge clk)
      if (!rst_n) AST_RESET_QUIET: assert (line_req == '0 && !any_req && ctl_q == '0); // R1

   AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
      any_req == (line_req != '0)); // R10

   AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((line_req & $past(line_req)) == $past(line_req))); // R8

   AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((line_req & $past(line_req & wdata[NLINES-1:0]))
                   == $past(line_req & wdata[NLINES-1:0]))); // R8

   genvar i;
   for (i = 0; i < NLINES; i++) begin : g_lvl
      AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (age == 2'd3 && $past(ctl_q[2*i +: 2]) == 2'b00 && $past(irq_in[i], 3) == 1'b0)
         |-> line_req[i]); // R3
   end
endmodule

bind xirq_sense xirq_sense_chk #(.NLINES(NLINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .ctl_q(ctl_q), .line_req(line_req), .any_req(any_req)
);

// File: tb/sim_xirq_sense.sv
`timescale 1ns/1ps
module sim_xirq_sense;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = 8'hFF;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] line_req;
   logic       any_req;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   xirq_sense u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .line_req(line_req), .any_req(any_req)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
   endtask

   task automatic check_reg(logic [1:0] a, logic [7:0] exp, string req);
      addr = a; #1;
      checks++;
      if (rdata !== exp) begin
         failures++;
         $display("FAIL %s addr=%0d rdata=%02h expected=%02h", req, a, rdata, exp);
      end
      addr = 2'd0;
   endtask

   task automatic check_flags(logic [7:0] exp, string req);
      check_reg(2'd2, exp, req);
      checks++;
      if (line_req !== exp || any_req !== (exp != 8'h00)) begin
         failures++;
         $display("FAIL %s/R10 line_req=%02h any_req=%0b expected=%02h any=%0b",
                  req, line_req, any_req, exp, exp != 8'h00);
      end
   endtask

   task automatic t_reset();
      check_reg(2'd0, 8'h00, "R1");
      check_reg(2'd1, 8'h00, "R1");
      check_flags(8'h00, "R1");
   endtask

   task automatic t_ctrl_rw();
      wr(2'd0, 8'hA5);
      wr(2'd1, 8'h3C);
      check_reg(2'd0, 8'hA5, "R2");
      check_reg(2'd1, 8'h3C, "R2");
      check_flags(8'h00, "R2");
      // lines 3..0 = both,both,rise,fall ; lines 7..4 = fall
      wr(2'd0, 8'hF9);
      wr(2'd1, 8'h55);
      check_reg(2'd0, 8'hF9, "R2");
   endtask

   task automatic t_edges();
      irq_in[1:0] = 2'b00;
      tick(2);
      check_flags(8'h00, "R7");
      tick(1);
      check_flags(8'h01, "R4");
      irq_in[1:0] = 2'b11;
      tick(3);
      check_flags(8'h03, "R5");
      irq_in[2] = 1'b0;
      tick(3);
      check_flags(8'h07, "R6");
      wr(2'd2, 8'hFB);
      check_flags(8'h03, "R8");
      irq_in[2] = 1'b1;
      tick(3);
      check_flags(8'h07, "R6");
   endtask

   task automatic t_clear();
      wr(2'd2, 8'hFE);
      check_flags(8'h06, "R8");
      wr(2'd2, 8'hFF);
      check_flags(8'h06, "R8");
      wr(2'd2, 8'h00);
      check_flags(8'h00, "R8");
      wr(2'd2, 8'hFF);
      check_flags(8'h00, "R8");
   endtask

   task automatic t_level();
      wr(2'd1, 8'h54);
      tick(3);
      check_flags(8'h00, "R3");
      irq_in[4] = 1'b0;
      tick(3);
      check_flags(8'h10, "R3");
      wr(2'd2, 8'h00);
      check_flags(8'h10, "R3");
      irq_in[4] = 1'b1;
      tick(3);
      check_flags(8'h10, "R3");
      wr(2'd2, 8'h00);
      check_flags(8'h00, "R3");
   endtask

   task automatic t_collide();
      irq_in[1] = 1'b0;
      tick(3);
      irq_in[1] = 1'b1;
      tick(3);
      check_flags(8'h02, "R9");
      irq_in[1] = 1'b0;
      tick(3);
      irq_in[1] = 1'b1;
      tick(2);
      wr(2'd2, 8'hFD);
      check_flags(8'h02, "R9");
      tick(2);
      wr(2'd2, 8'hFD);
      check_flags(8'h00, "R9");
   endtask

   task automatic t_addr3();
      irq_in[0] = 1'b0;
      tick(3);
      check_flags(8'h01, "R11");
      wr(2'd3, 8'h00);
      check_reg(2'd3, 8'h00, "R11");
      check_flags(8'h01, "R11");
      check_reg(2'd0, 8'hF9, "R11");
      check_reg(2'd1, 8'h54, "R11");
      irq_in[0] = 1'b1;
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_ctrl_rw();
      t_edges();
      t_clear();
      t_level();
      t_collide();
      t_addr3();
      tick(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule